// File: doc/BRIEF.md
# Peripheral Control Register Bank

This block holds the 16-bit control registers of a small handheld-style system and serves them on a simple synchronous bus. The bus carries a halfword-aligned byte address, 16-bit write data, a halfword write strobe, a byte write strobe and a read strobe. Read data is registered: it appears on `rdata_o` in the cycle after the read strobe is sampled, and it holds until the next read.

Each register applies its own rules. Some have non-zero reset values and some have write masks. Some are read-only, so they reflect inputs, and some are write-only, so they read as zero. Sound registers read as zero while the sound master enable is off. The interrupt flags are set by hardware and cleared by writing ones. A debug register turns on only when a magic value is written to it. The video, sound, DMA and timer engines are not part of this block. They appear only as interrupt request inputs, a few status inputs, and the DMA word-count outputs.

Byte writes take the byte from `wdata_i[7:0]`. They merge that byte into the addressed lane of the register's stored halfword, and the merged halfword then goes through the same masking as a halfword write. If both write strobes are high together, the halfword write is used.

Top module: `ctrl_reg_bank`

## Requirements
- R1: After reset, reads return the following values. Display control (0x000) reads 0x0080. Key state (0x100) reads 0x03FF. Sound bias (0x04C) reads 0x0200. The diagonal coefficients of both rotating backgrounds read 0x0100: layer A at 0x010 and 0x016, layer B at 0x018 and 0x01E. Every other register, including the off-diagonal coefficients, reads 0. The flags output, the sound enable output and the debug output are 0.
- R2: A write to display status (0x002) stores bits 15..3. A read returns those stored bits with bits 2..0 taken from `disp_status_i`.
- R3: The line counter (0x004) reads `line_i`, zero-extended. Key state (0x100) reads `keys_ni` as sampled one cycle earlier. Writes to either register have no effect.
- R4: Each of the four timer control registers (0x080, 0x084, 0x088, 0x08C) stores only the bits of mask 0x00C7.
- R5: A write to the interrupt flag register (0x200) clears each flag whose written bit is 1 and keeps each flag whose written bit is 0. A byte write clears only within the addressed lane. Flags never clear without such a write.
- R6: Bit n of `irq_req_i` sets flag n in the next cycle. If the same bit is cleared by a write in that same cycle, the set wins.
- R7: A byte write replaces only the addressed lane, where address bit 0 = 1 selects bits 15..8. It keeps the other lane of the stored value and then applies the register's mask. A halfword write overrides a byte write issued in the same cycle.
- R8: A write to the sound master register (0x04A) stores only bit 7, which drives `snd_enable_o`. Reads return bit 7 together with `snd_status_i` in bits 3..0.
- R9: While the sound enable is 0, reads of the four channel controls (0x040 to 0x046) and of the mixer control (0x048) return 0. Writes to them are still stored and read back once the enable is 1.
- R10: Reads of the four DMA word-count registers (0x060, 0x064, 0x068, 0x06C) return 0. The written values appear on `dma_count_o`, with channel k at bits 16k+15..16k.
- R11: A halfword write of 0xC0DE to the debug register (0x300) sets `debug_en_o`, and any other write to it clears `debug_en_o`. The register reads 0x1DEA while debug mode is on and 0 while it is off.
- R12: Reads of unmapped addresses return 0. Writes to unmapped addresses change no register.
- R13: `rdata_o` is loaded only on a cycle where `rd_i` is sampled high, and it keeps its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 10 | Byte address; bit 0 selects the lane for byte writes |
| wdata_i | input | 16 | Write data (byte writes use bits 7..0) |
| wr_half_i | input | 1 | Halfword write strobe |
| wr_byte_i | input | 1 | Byte write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Registered read data |
| irq_req_i | input | 16 | Hardware interrupt set requests |
| disp_status_i | input | 3 | Display status bits owned by hardware |
| snd_status_i | input | 4 | Sound channel status bits owned by hardware |
| line_i | input | 8 | Current display line |
| keys_ni | input | 10 | Key state, active low |
| irq_flags_o | output | 16 | Interrupt flag register |
| snd_enable_o | output | 1 | Sound master enable |
| debug_en_o | output | 1 | Debug mode active |
| dma_count_o | output | 64 | DMA word counts, four channels |

## Verification
Most stored state reaches the ports only through a read, one cycle after the strobe. A wrong mask, reset value or lane merge therefore shows up on the first read of that register after the faulty write. A flag that is lost or cleared without cause shows up on `irq_flags_o` one cycle after the edge that caused it. A stuck sound enable is seen in two ways: on `snd_enable_o`, and as channel reads that return stored data or zero when they should not. The debug unlock shows on `debug_en_o` in the cycle after the write, and on the very next read of that address.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 16;
  localparam int LINE_W   = 8;
  localparam int KEY_W    = 10;
  localparam int DSTAT_W  = 3;
  localparam int SSTAT_W  = 4;
  localparam int BG_N     = 2;
  localparam int SND_CH_N = 4;
  localparam int DMA_N    = 4;
  localparam int TMR_N    = 4;
  localparam int SND_EN_BIT = 7;

  localparam int IX_DCTL  = 0;
  localparam int IX_DSTAT = 1;
  localparam int IX_BG    = 2;
  localparam int IX_SCH   = IX_BG + 4 * BG_N;
  localparam int IX_SMIX  = IX_SCH + SND_CH_N;
  localparam int IX_SMST  = IX_SMIX + 1;
  localparam int IX_SBIAS = IX_SMST + 1;
  localparam int IX_DMA   = IX_SBIAS + 1;
  localparam int IX_TMR   = IX_DMA + DMA_N;
  localparam int N_PLAIN  = IX_TMR + TMR_N;

  localparam logic [ADDR_W-1:0] A_DCTL  = 10'h000;
  localparam logic [ADDR_W-1:0] A_DSTAT = 10'h002;
  localparam logic [ADDR_W-1:0] A_LINE  = 10'h004;
  localparam logic [ADDR_W-1:0] A_BG    = 10'h010;
  localparam logic [ADDR_W-1:0] A_SCH   = 10'h040;
  localparam logic [ADDR_W-1:0] A_SMIX  = 10'h048;
  localparam logic [ADDR_W-1:0] A_SMST  = 10'h04A;
  localparam logic [ADDR_W-1:0] A_SBIAS = 10'h04C;
  localparam logic [ADDR_W-1:0] A_DMA   = 10'h060;
  localparam logic [ADDR_W-1:0] A_TMR   = 10'h080;
  localparam logic [ADDR_W-1:0] A_KEYS  = 10'h100;
  localparam logic [ADDR_W-1:0] A_IRQ   = 10'h200;
  localparam logic [ADDR_W-1:0] A_DBG   = 10'h300;

  localparam logic [DATA_W-1:0] DBG_KEY  = 16'hC0DE;
  localparam logic [DATA_W-1:0] DBG_SIGN = 16'h1DEA;

  typedef enum logic [1:0] {RD_PLAIN, RD_SND_GATED, RD_NONE} rd_kind_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] rst;
    logic [DATA_W-1:0] mask;
    rd_kind_e          kind;
  } reg_desc_t;

  function automatic reg_desc_t reg_desc(input int idx);
    reg_desc_t d;
    int k;
    d.addr = '0;
    d.rst  = '0;
    d.mask = '1;
    d.kind = RD_PLAIN;
    if (idx == IX_DCTL) begin
      d.addr = A_DCTL;
      d.rst  = 16'h0080;
    end else if (idx == IX_DSTAT) begin
      d.addr = A_DSTAT;
      d.mask = 16'hFFF8;
    end else if (idx < IX_SCH) begin
      k = idx - IX_BG;
      d.addr = A_BG + ADDR_W'(2 * k);
      d.rst  = ((k % 4 == 0) || (k % 4 == 3)) ? 16'h0100 : 16'h0000;
    end else if (idx < IX_SMIX) begin
      d.addr = A_SCH + ADDR_W'(2 * (idx - IX_SCH));
      d.kind = RD_SND_GATED;
    end else if (idx == IX_SMIX) begin
      d.addr = A_SMIX;
      d.kind = RD_SND_GATED;
    end else if (idx == IX_SMST) begin
      d.addr = A_SMST;
      d.mask = 16'h0001 << SND_EN_BIT;
    end else if (idx == IX_SBIAS) begin
      d.addr = A_SBIAS;
      d.rst  = 16'h0200;
    end else if (idx < IX_TMR) begin
      d.addr = A_DMA + ADDR_W'(4 * (idx - IX_DMA));
      d.kind = RD_NONE;
    end else begin
      d.addr = A_TMR + ADDR_W'(4 * (idx - IX_TMR));
      d.mask = 16'h00C7;
    end
    return d;
  endfunction
endpackage

// File: rtl/crb_lane_merge.sv
module crb_lane_merge #(
  parameter int DATA_W = 16
) (
  input  logic              byte_i,
  input  logic              lane_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cur_i,
  output logic [DATA_W-1:0] merged_o,
  output logic [DATA_W-1:0] lane_only_o
);
  localparam int LANE_W = DATA_W / 2;

  always_comb begin
    merged_o    = wdata_i;
    lane_only_o = wdata_i;
    if (byte_i) begin
      if (lane_i) begin
        merged_o    = {wdata_i[LANE_W-1:0], cur_i[LANE_W-1:0]};
        lane_only_o = {wdata_i[LANE_W-1:0], {LANE_W{1'b0}}};
      end else begin
        merged_o    = {cur_i[DATA_W-1:LANE_W], wdata_i[LANE_W-1:0]};
        lane_only_o = {{LANE_W{1'b0}}, wdata_i[LANE_W-1:0]};
      end
    end
  end
endmodule

// File: rtl/crb_field_reg.sv
module crb_field_reg #(
  parameter int                 DATA_W = 16,
  parameter logic [DATA_W-1:0]  RST    = '0,
  parameter logic [DATA_W-1:0]  MASK   = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST;
    else if (we_i) q_o <= d_i & MASK;
  end
endmodule

// File: rtl/crb_irq_flags.sv
module crb_irq_flags #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] clr_eff;
  assign clr_eff = clr_we_i ? clr_i : '0;

  // set dominates a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= (flags_o & ~clr_eff) | set_i;
  end
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import crb_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic                    wr_half_i,
  input  logic                    wr_byte_i,
  input  logic                    rd_i,
  output logic [DATA_W-1:0]       rdata_o,
  input  logic [DATA_W-1:0]       irq_req_i,
  input  logic [DSTAT_W-1:0]      disp_status_i,
  input  logic [SSTAT_W-1:0]      snd_status_i,
  input  logic [LINE_W-1:0]       line_i,
  input  logic [KEY_W-1:0]        keys_ni,
  output logic [DATA_W-1:0]       irq_flags_o,
  output logic                    snd_enable_o,
  output logic                    debug_en_o,
  output logic [DMA_N*DATA_W-1:0] dma_count_o
);
  localparam int HW = ADDR_W - 1;

  logic              wr_any, byte_mode;
  logic [HW-1:0]     hw_addr;
  logic [N_PLAIN-1:0] hit;
  logic [DATA_W-1:0] q       [N_PLAIN];
  logic [DATA_W-1:0] rd_part [N_PLAIN];
  logic [DATA_W-1:0] cur, merged, lane_only, rd_val;
  logic [KEY_W-1:0]  key_q;
  logic              dbg_q, snd_en;

  assign wr_any    = wr_half_i | wr_byte_i;
  assign byte_mode = wr_byte_i & ~wr_half_i;
  assign hw_addr   = addr_i[ADDR_W-1:1];
  assign snd_en    = q[IX_SMST][SND_EN_BIT];

  always_comb begin
    cur = '0;
    for (int i = 0; i < N_PLAIN; i++) if (hit[i]) cur |= q[i];
  end

  crb_lane_merge #(.DATA_W(DATA_W)) u_merge (
    .byte_i     (byte_mode),
    .lane_i     (addr_i[0]),
    .wdata_i    (wdata_i),
    .cur_i      (cur),
    .merged_o   (merged),
    .lane_only_o(lane_only)
  );

  for (genvar g = 0; g < N_PLAIN; g++) begin : g_reg
    localparam reg_desc_t D = reg_desc(g);
    assign hit[g] = (hw_addr == D.addr[ADDR_W-1:1]);
    crb_field_reg #(.DATA_W(DATA_W), .RST(D.rst), .MASK(D.mask)) u_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (wr_any & hit[g]),
      .d_i   (merged),
      .q_o   (q[g])
    );
    if (D.kind == RD_NONE) begin : g_wo
      assign rd_part[g] = '0;
    end else if (D.kind == RD_SND_GATED) begin : g_gated
      assign rd_part[g] = (hit[g] && snd_en) ? q[g] : '0;
    end else begin : g_plain
      assign rd_part[g] = hit[g] ? q[g] : '0;
    end
  end

  for (genvar k = 0; k < DMA_N; k++) begin : g_dma
    assign dma_count_o[k*DATA_W +: DATA_W] = q[IX_DMA + k];
  end

  crb_irq_flags #(.W(DATA_W)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_we_i(wr_any && hw_addr == A_IRQ[ADDR_W-1:1]),
    .clr_i   (lane_only),
    .set_i   (irq_req_i),
    .flags_o (irq_flags_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '1;
      dbg_q <= 1'b0;
    end else begin
      key_q <= keys_ni;
      if (wr_any && hw_addr == A_DBG[ADDR_W-1:1]) dbg_q <= (merged == DBG_KEY);
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < N_PLAIN; i++) rd_val |= rd_part[i];
    if (hit[IX_DSTAT]) rd_val |= {{(DATA_W-DSTAT_W){1'b0}}, disp_status_i};
    if (hit[IX_SMST])  rd_val |= {{(DATA_W-SSTAT_W){1'b0}}, snd_status_i};
    if (hw_addr == A_LINE[ADDR_W-1:1]) rd_val = {{(DATA_W-LINE_W){1'b0}}, line_i};
    if (hw_addr == A_KEYS[ADDR_W-1:1]) rd_val = {{(DATA_W-KEY_W){1'b0}}, key_q};
    if (hw_addr == A_IRQ[ADDR_W-1:1])  rd_val = irq_flags_o;
    if (hw_addr == A_DBG[ADDR_W-1:1])  rd_val = dbg_q ? DBG_SIGN : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_val;
  end

  assign snd_enable_o = snd_en;
  assign debug_en_o   = dbg_q;
endmodule

// File: rtl/crb_checker.sv
module crb_checker
  import crb_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              wr_half_i,
  input logic              wr_byte_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] irq_req_i,
  input logic [DATA_W-1:0] irq_flags_o,
  input logic              snd_enable_o,
  input logic              debug_en_o
);
  localparam logic [ADDR_W-1:0] A_HOLE = 10'h3F0;

  logic wr_any, at_irq, at_smst, at_dbg;
  assign wr_any  = wr_half_i | wr_byte_i;
  assign at_irq  = addr_i[ADDR_W-1:1] == A_IRQ[ADDR_W-1:1];
  assign at_smst = addr_i[ADDR_W-1:1] == A_SMST[ADDR_W-1:1];
  assign at_dbg  = addr_i[ADDR_W-1:1] == A_DBG[ADDR_W-1:1];

  assert_irq_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ((irq_flags_o & $past(irq_req_i)) == $past(irq_req_i)));

  assert_no_spurious_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_any && at_irq) |=> ((irq_flags_o & $past(irq_flags_o)) == $past(irq_flags_o)));

  assert_dbg_unlock_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_half_i && at_dbg && wdata_i == DBG_KEY) |=> debug_en_o);

  assert_dbg_lock_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_half_i && at_dbg && wdata_i != DBG_KEY) |=> !debug_en_o);

  assert_snd_en_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_any && at_smst) |=> $stable(snd_enable_o));

  assert_rdata_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  assert_hole_reads_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_HOLE) |=> rdata_o == '0);
endmodule

bind ctrl_reg_bank crb_checker i_crb_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .wr_half_i   (wr_half_i),
  .wr_byte_i   (wr_byte_i),
  .rd_i        (rd_i),
  .rdata_o     (rdata_o),
  .irq_req_i   (irq_req_i),
  .irq_flags_o (irq_flags_o),
  .snd_enable_o(snd_enable_o),
  .debug_en_o  (debug_en_o)
);

// File: tb/test_ctrl_reg_bank.sv
module test_ctrl_reg_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        wr_half_i = 1'b0, wr_byte_i = 1'b0, rd_i = 1'b0;
  logic [15:0] rdata_o;
  logic [15:0] irq_req_i = '0;
  logic [2:0]  disp_status_i = '0;
  logic [3:0]  snd_status_i = '0;
  logic [7:0]  line_i = '0;
  logic [9:0]  keys_ni = 10'h3FF;
  logic [15:0] irq_flags_o;
  logic        snd_enable_o, debug_en_o;
  logic [63:0] dma_count_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  ctrl_reg_bank i_ctrl_reg_bank (.*);

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_h(input logic [9:0] a, input logic [15:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_half_i = 1'b1;
    @(negedge clk_i); wr_half_i = 1'b0;
  endtask

  task automatic wr_b(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = {8'h00, d}; wr_byte_i = 1'b1;
    @(negedge clk_i); wr_byte_i = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [15:0] v);
    @(negedge clk_i); addr_i = a; rd_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0; v = rdata_o;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(10'h000, v); check("R1 disp ctrl", v, 16'h0080);
    rd(10'h010, v); check("R1 bgA diag0", v, 16'h0100);
    rd(10'h012, v); check("R1 bgA offdiag", v, 16'h0000);
    rd(10'h016, v); check("R1 bgA diag1", v, 16'h0100);
    rd(10'h018, v); check("R1 bgB diag0", v, 16'h0100);
    rd(10'h01E, v); check("R1 bgB diag1", v, 16'h0100);
    rd(10'h04C, v); check("R1 sound bias", v, 16'h0200);
    rd(10'h100, v); check("R1 keys", v, 16'h03FF);
    rd(10'h080, v); check("R1 timer ctrl", v, 16'h0000);
    check("R1 outputs", {irq_flags_o, snd_enable_o, debug_en_o}, '0);
  endtask

  task automatic t_disp_stat;
    logic [15:0] v;
    disp_status_i = 3'b101;
    wr_h(10'h002, 16'hFFFF);
    rd(10'h002, v); check("R2 disp status", v, 16'hFFFD);
    disp_status_i = 3'b010;
    rd(10'h002, v); check("R2 disp status hw bits", v, 16'hFFFA);
  endtask

  task automatic t_readonly;
    logic [15:0] v;
    line_i = 8'h7E;
    rd(10'h004, v); check("R3 line read", v, 16'h007E);
    wr_h(10'h004, 16'hFFFF);
    line_i = 8'h12;
    rd(10'h004, v); check("R3 line after write", v, 16'h0012);
    @(negedge clk_i); keys_ni = 10'h2A5;
    rd(10'h100, v); check("R3 keys sample", v, 16'h02A5);
    wr_h(10'h100, 16'h0000);
    rd(10'h100, v); check("R3 keys write ignored", v, 16'h02A5);
  endtask

  task automatic t_timer;
    logic [15:0] v;
    wr_h(10'h084, 16'hFFFF);
    rd(10'h084, v); check("R4 timer1 mask", v, 16'h00C7);
    wr_h(10'h08C, 16'h1234);
    rd(10'h08C, v); check("R4 timer3 mask", v, 16'h0004);
  endtask

  task automatic t_irq;
    logic [15:0] v;
    @(negedge clk_i); irq_req_i = 16'hFFFF;
    @(negedge clk_i); irq_req_i = 16'h0000;
    check("R6 set all", irq_flags_o, 16'hFFFF);
    wr_h(10'h200, 16'h0005);
    check("R5 w1c", irq_flags_o, 16'hFFFA);
    wr_b(10'h201, 8'h01);
    check("R5 byte w1c high lane", irq_flags_o, 16'hFEFA);
    @(negedge clk_i); addr_i = 10'h200; wdata_i = 16'h000A; wr_half_i = 1'b1; irq_req_i = 16'h0002;
    @(negedge clk_i); wr_half_i = 1'b0; irq_req_i = 16'h0000;
    check("R6 set beats clear", irq_flags_o, 16'hFEF2);
    rd(10'h200, v); check("R5 flags readback", v, 16'hFEF2);
  endtask

  task automatic t_bytes;
    logic [15:0] v;
    wr_h(10'h000, 16'h1234);
    wr_b(10'h001, 8'hAB);
    rd(10'h000, v); check("R7 byte high lane", v, 16'hAB34);
    wr_b(10'h000, 8'hCD);
    rd(10'h000, v); check("R7 byte low lane", v, 16'hABCD);
    @(negedge clk_i); addr_i = 10'h000; wdata_i = 16'h5678; wr_half_i = 1'b1; wr_byte_i = 1'b1;
    @(negedge clk_i); wr_half_i = 1'b0; wr_byte_i = 1'b0;
    rd(10'h000, v); check("R7 halfword priority", v, 16'h5678);
    wr_b(10'h080, 8'hFF);
    rd(10'h080, v); check("R7 byte then mask", v, 16'h00C7);
    wr_b(10'h081, 8'hFF);
    rd(10'h080, v); check("R7 high byte masked", v, 16'h00C7);
  endtask

  task automatic t_sound;
    logic [15:0] v;
    snd_status_i = 4'hA;
    rd(10'h040, v); check("R9 gated at reset", v, 16'h0000);
    wr_h(10'h04A, 16'hFFFF);
    check("R8 enable out", snd_enable_o, 1'b1);
    rd(10'h04A, v); check("R8 master read", v, 16'h008A);
    wr_h(10'h040, 16'hBEEF);
    wr_h(10'h048, 16'h1111);
    rd(10'h040, v); check("R9 channel enabled", v, 16'hBEEF);
    rd(10'h048, v); check("R9 mixer enabled", v, 16'h1111);
    wr_h(10'h04A, 16'h0000);
    check("R8 enable off", snd_enable_o, 1'b0);
    rd(10'h04A, v); check("R8 master read off", v, 16'h000A);
    rd(10'h040, v); check("R9 channel gated", v, 16'h0000);
    rd(10'h048, v); check("R9 mixer gated", v, 16'h0000);
    wr_h(10'h046, 16'h4321);
    wr_h(10'h04A, 16'h0080);
    rd(10'h040, v); check("R9 kept value", v, 16'hBEEF);
    rd(10'h046, v); check("R9 write while off", v, 16'h4321);
  endtask

  task automatic t_dma;
    logic [15:0] v;
    wr_h(10'h064, 16'hFFFF);
    wr_h(10'h06C, 16'h00A5);
    rd(10'h064, v); check("R10 dma read zero", v, 16'h0000);
    check("R10 dma count out", dma_count_o, 64'h00A5_0000_FFFF_0000);
  endtask

  task automatic t_debug;
    logic [15:0] v;
    rd(10'h300, v); check("R11 locked read", v, 16'h0000);
    wr_h(10'h300, 16'hC0DE);
    check("R11 unlock", debug_en_o, 1'b1);
    rd(10'h300, v); check("R11 signature", v, 16'h1DEA);
    wr_h(10'h300, 16'h1234);
    check("R11 relock", debug_en_o, 1'b0);
    rd(10'h300, v); check("R11 relocked read", v, 16'h0000);
  endtask

  task automatic t_unmapped;
    logic [15:0] v;
    wr_h(10'h3F0, 16'hFFFF);
    rd(10'h3F0, v); check("R12 hole read", v, 16'h0000);
    rd(10'h006, v); check("R12 gap read", v, 16'h0000);
    rd(10'h04C, v); check("R12 neighbour intact", v, 16'h0200);
  endtask

  task automatic t_hold;
    logic [15:0] v;
    rd(10'h04C, v);
    @(negedge clk_i); addr_i = 10'h000;
    @(negedge clk_i); addr_i = 10'h200;
    @(negedge clk_i);
    check("R13 rdata hold", rdata_o, 16'h0200);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_disp_stat();
    t_readonly();
    t_timer();
    t_irq();
    t_bytes();
    t_sound();
    t_dma();
    t_debug();
    t_unmapped();
    t_hold();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule